// File: doc/BRIEF.md
# Seek Completion Interrupt Arbiter

This block keeps the interrupt state for the positioning commands of a four-drive floppy disk controller. Each drive has a slot that holds a pending status byte and a register that holds its present cylinder. A completed seek or recalibrate event writes that drive's slot. A fixed number of clock cycles after the event, the block raises an interrupt request line.

When the host later issues a sense-interrupt-status command, the sequencer pulses a request and gives the currently selected unit. The block then picks one pending drive and returns its status byte and cylinder, and it empties that slot. It drops the interrupt once nothing is left to report. If there is nothing to report, it returns a single invalid-command code. The step-pulse timing and the parsing of command bytes belong to neighbouring blocks.

Top module: `seek_irq_arbiter`

## Requirements
- R1: A seek or recalibrate event stores, in the slot of `ev_unit`, the status 0x20 (seek end, bit 5) OR `ev_head` in bit 2 OR `ev_unit` in bits 1:0.
- R2: When the drive is ready, a recalibrate sets that unit's present cylinder to 0 and a seek sets it to `ev_cyl`. The cylinder is returned as the second result byte.
- R3: The status gains flags when the drive is not ready, where not-ready is bit 3 (0x08) and abnormal termination is bits 7:6 = 01 (0x40). A unit whose `equipped` bit is 0 gains 0x48 for either command. An equipped unit whose `media` bit is 0 gains 0x48 on a seek and only 0x08 on a recalibrate. A not-ready event leaves the present cylinder unchanged.
- R4: `irq` rises exactly IRQ_DELAY rising edges after the edge that samples `ev_valid`. A new event restarts the count.
- R5: On a sense request with `irq` high, if the slot of `sel_unit` is nonzero, that unit is reported.
- R6: Otherwise, units 0 to 3 are scanned in ascending order and the first nonzero slot is reported.
- R7: A report has `res_count` = 2, `res_status` = the slot and `res_cyl` = the present cylinder. The reported slot is then zero.
- R8: `irq` falls only on a sense request, and only when no slot stays nonzero after the reported one is removed.
- R9: A sense request while `irq` is low, or while no slot is pending, returns `res_count` = 1 and `res_status` = 0x80. It leaves every slot unchanged.
- R10: `res_valid` is high exactly in the cycle after a cycle with `sense_req` high.
- R11: After reset, `irq` is low, every slot is empty and every present cylinder is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Seek or recalibrate event this cycle |
| ev_recal | input | 1 | 1 for recalibrate, 0 for seek |
| ev_unit | input | 2 | Target unit |
| ev_head | input | 1 | Head select of the command |
| ev_cyl | input | 8 | Target cylinder of a seek |
| equipped | input | 4 | Per-unit drive fitted mask |
| media | input | 4 | Per-unit medium present mask |
| sense_req | input | 1 | Sense-interrupt-status command request |
| sel_unit | input | 2 | Currently selected unit |
| irq | output | 1 | Interrupt request |
| res_valid | output | 1 | Result bytes valid |
| res_count | output | 2 | Number of result bytes, 1 or 2 |
| res_status | output | 8 | First result byte |
| res_cyl | output | 8 | Second result byte (present cylinder) |

## Verification
The assertions check on every cycle the properties that hold at any moment:
- a result follows each request by one cycle and never appears without one;
- a single-byte result always carries 0x80;
- a two-byte result always carries the seek-end flag;
- `irq` never falls without a sense request, and never rises directly after an event.

Other behaviours depend on the history of several events, so only the bench scenarios can show them:
- the exact delay and its restart;
- the choice between the selected unit and the ascending scan;
- the status and cylinder values in the ready and not-ready cases;
- the point at which the last drain drops `irq`.

// File: rtl/seek_irq_arbiter.sv
module seek_irq_arbiter #(
  parameter int UNITS     = 4,
  parameter int CYL_W     = 8,
  parameter int IRQ_DELAY = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ev_valid,
  input  logic                     ev_recal,
  input  logic [$clog2(UNITS)-1:0] ev_unit,
  input  logic                     ev_head,
  input  logic [CYL_W-1:0]         ev_cyl,
  input  logic [UNITS-1:0]         equipped,
  input  logic [UNITS-1:0]         media,
  input  logic                     sense_req,
  input  logic [$clog2(UNITS)-1:0] sel_unit,
  output logic                     irq,
  output logic                     res_valid,
  output logic [1:0]               res_count,
  output logic [7:0]               res_status,
  output logic [CYL_W-1:0]         res_cyl
);
  localparam int UW = $clog2(UNITS);
  localparam int TW = $clog2(IRQ_DELAY + 1);
  localparam logic [7:0] SEEK_END  = 8'h20;
  localparam logic [7:0] NOT_READY = 8'h08;
  localparam logic [7:0] ABNORMAL  = 8'h40;
  localparam logic [7:0] BAD_CMD   = 8'h80;

  logic [7:0]       slot [UNITS];
  logic [CYL_W-1:0] pcn  [UNITS];
  logic [TW-1:0]    timer;
  logic [UNITS-1:0] pend, remaining;
  logic [UW-1:0]    pick;
  logic             found;

  wire no_drive = !equipped[ev_unit];
  wire no_media = !media[ev_unit];
  wire ready    = !no_drive && !no_media;
  wire [7:0] flags = no_drive ? (NOT_READY | ABNORMAL) :
                     no_media ? (ev_recal ? NOT_READY : (NOT_READY | ABNORMAL)) : 8'h00;
  wire [7:0] new_stat = SEEK_END | flags | 8'({ev_head, ev_unit});
  wire [CYL_W-1:0] new_cyl = ev_recal ? '0 : ev_cyl;
  wire report = sense_req && irq && found;

  always_comb begin
    for (int i = 0; i < UNITS; i++) pend[i] = |slot[i];
    pick  = sel_unit;
    found = pend[sel_unit];
    if (!found) begin
      for (int i = UNITS - 1; i >= 0; i--) begin
        if (pend[i]) begin
          pick  = UW'(i);
          found = 1'b1;
        end
      end
    end
    remaining = pend;
    if (found) remaining[pick] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < UNITS; i++) begin
        slot[i] <= '0;
        pcn[i]  <= '0;
      end
      timer      <= '0;
      irq        <= 1'b0;
      res_valid  <= 1'b0;
      res_count  <= 2'd0;
      res_status <= 8'h00;
      res_cyl    <= '0;
    end else begin
      res_valid <= sense_req;
      if (sense_req) begin
        if (report) begin
          res_count  <= 2'd2;
          res_status <= slot[pick];
          res_cyl    <= pcn[pick];
          slot[pick] <= '0;
          if (remaining == '0) irq <= 1'b0;
        end else begin
          res_count  <= 2'd1;
          res_status <= BAD_CMD;
          res_cyl    <= '0;
          irq        <= 1'b0;
        end
      end
      if (ev_valid) begin
        timer <= TW'(IRQ_DELAY);
      end else if (timer != '0) begin
        timer <= timer - 1'b1;
        if (timer == TW'(1)) irq <= 1'b1;
      end
      if (ev_valid) begin
        slot[ev_unit] <= new_stat;
        if (ready) pcn[ev_unit] <= new_cyl;
      end
    end
  end
endmodule

module seek_irq_arbiter_chk #(
  parameter int UNITS = 4,
  parameter int CYL_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ev_valid,
  input logic                     sense_req,
  input logic                     irq,
  input logic                     res_valid,
  input logic [1:0]               res_count,
  input logic [7:0]               res_status
);
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    sense_req |=> res_valid); // R10
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !sense_req |=> !res_valid); // R10
  AST_EMPTY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_count == 2'd1) |-> res_status == 8'h80); // R9
  AST_IDLE_SENSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_req && !irq) |=> res_count == 2'd1); // R9
  AST_SEEK_END_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_count == 2'd2) |-> res_status[5]); // R1
  AST_COUNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_count == 2'd1 || res_count == 2'd2)); // R7
  AST_IRQ_FALL_BY_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(sense_req)); // R8
  AST_IRQ_NOT_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !$past(ev_valid)); // R4
endmodule

bind seek_irq_arbiter seek_irq_arbiter_chk #(.UNITS(UNITS), .CYL_W(CYL_W)) u_chk (.*);

// File: tb/seek_irq_arbiter_bench.sv
module seek_irq_arbiter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0, ev_recal = 1'b0, ev_head = 1'b0, sense_req = 1'b0;
  logic [1:0] ev_unit = 2'd0, sel_unit = 2'd0;
  logic [7:0] ev_cyl = 8'h00;
  logic [3:0] equipped = 4'hF, media = 4'hF;
  logic irq, res_valid;
  logic [1:0] res_count;
  logic [7:0] res_status, res_cyl;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seek_irq_arbiter u_seek_irq_arbiter (.*);

  // {recal, unit[2], head, cyl[8], equipped bit, media bit, status[8], cylinder[8]}
  localparam logic [29:0] VEC [8] = '{
    {1'b0, 2'd0, 1'b0, 8'h25, 1'b1, 1'b1, 8'h20, 8'h25},
    {1'b1, 2'd1, 1'b1, 8'h99, 1'b1, 1'b1, 8'h25, 8'h00},
    {1'b0, 2'd2, 1'b0, 8'h4F, 1'b1, 1'b1, 8'h22, 8'h4F},
    {1'b0, 2'd2, 1'b1, 8'h10, 1'b0, 1'b1, 8'h6E, 8'h4F},
    {1'b0, 2'd3, 1'b0, 8'h33, 1'b1, 1'b0, 8'h6B, 8'h00},
    {1'b1, 2'd3, 1'b0, 8'h00, 1'b1, 1'b0, 8'h2B, 8'h00},
    {1'b1, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h68, 8'h25},
    {1'b0, 2'd3, 1'b1, 8'hFF, 1'b1, 1'b1, 8'h27, 8'hFF}
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic event_in(input logic rc, input logic [1:0] u, input logic h, input logic [7:0] c);
    @(negedge clk);
    ev_valid = 1'b1; ev_recal = rc; ev_unit = u; ev_head = h; ev_cyl = c;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic sense(input logic [1:0] s);
    @(negedge clk);
    sense_req = 1'b1; sel_unit = s;
    @(negedge clk);
    sense_req = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    wait_cycles(3);
    rst_n = 1'b1;
    check({7'd0, irq}, 8'h00, "R11 irq after reset");
    sense(2'd0);
    check({6'd0, res_count}, 8'h01, "R11 R9 count after reset");
    check(res_status, 8'h80, "R11 R9 code after reset");
    check({7'd0, res_valid}, 8'h01, "R10 valid after request");
    wait_cycles(1);
    check({7'd0, res_valid}, 8'h00, "R10 valid drops");

    foreach (VEC[k]) begin
      logic [29:0] v;
      v = VEC[k];
      equipped = 4'hF; media = 4'hF;
      equipped[v[28:27]] = v[17];
      media[v[28:27]]    = v[16];
      event_in(v[29], v[28:27], v[26], v[25:18]);
      wait_cycles(512);
      check({7'd0, irq}, 8'h01, "R4 irq raised");
      sense(v[28:27]);
      check({6'd0, res_count}, 8'h02, "R7 count");
      check(res_status, v[15:8], "R1 R3 status byte");
      check(res_cyl, v[7:0], "R2 R3 cylinder byte");
      check({7'd0, irq}, 8'h00, "R8 irq drained");
    end
    equipped = 4'hF; media = 4'hF;

    event_in(1'b0, 2'd1, 1'b0, 8'h40);
    wait_cycles(511);
    check({7'd0, irq}, 8'h00, "R4 low one cycle early");
    wait_cycles(1);
    check({7'd0, irq}, 8'h01, "R4 high at delay");
    sense(2'd1);
    check(res_status, 8'h21, "R4 drain status");

    event_in(1'b0, 2'd1, 1'b0, 8'h41);
    wait_cycles(300);
    event_in(1'b0, 2'd1, 1'b0, 8'h42);
    wait_cycles(511);
    check({7'd0, irq}, 8'h00, "R4 restart holds off");
    wait_cycles(1);
    check({7'd0, irq}, 8'h01, "R4 restart fires");
    sense(2'd1);
    check(res_cyl, 8'h42, "R2 latest cylinder");
    check({7'd0, irq}, 8'h00, "R8 single slot drains");

    event_in(1'b0, 2'd0, 1'b0, 8'h11);
    sense(2'd0);
    check({6'd0, res_count}, 8'h01, "R9 early sense count");
    check(res_status, 8'h80, "R9 early sense code");
    wait_cycles(520);
    check({7'd0, irq}, 8'h01, "R9 irq after early sense");
    sense(2'd0);
    check(res_status, 8'h20, "R9 slot kept");
    check(res_cyl, 8'h11, "R9 cylinder kept");

    event_in(1'b0, 2'd3, 1'b0, 8'h05);
    event_in(1'b0, 2'd1, 1'b0, 8'h06);
    event_in(1'b0, 2'd2, 1'b0, 8'h07);
    wait_cycles(512);
    sense(2'd2);
    check(res_status, 8'h22, "R5 selected unit first");
    check(res_cyl, 8'h07, "R5 selected cylinder");
    check({7'd0, irq}, 8'h01, "R8 irq held with pending");
    sense(2'd0);
    check(res_status, 8'h21, "R6 ascending scan picks unit 1");
    check(res_cyl, 8'h06, "R6 cylinder of unit 1");
    check({7'd0, irq}, 8'h01, "R8 irq still held");
    sense(2'd1);
    check(res_status, 8'h23, "R6 scan picks unit 3");
    check({7'd0, irq}, 8'h00, "R8 irq cleared on last");
    sense(2'd3);
    check({6'd0, res_count}, 8'h01, "R9 nothing pending count");
    check(res_status, 8'h80, "R9 nothing pending code");
    check({7'd0, irq}, 8'h00, "R7 slots empty after drain");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule